// File: doc/BRIEF.md
# LCD Polarity Inversion Controller

This block produces the polarity control bit that a liquid-crystal panel needs to keep the cell voltage balanced over time. It watches the vertical and horizontal sync pulses and a pixel strobe. From these it forms a field-level base polarity and combines it with line and pixel parities. A 2-bit code selects one of four patterns: whole field, line by line, pixel column, or checkerboard.

The base polarity flips once per field, or once per two fields when the half-rate select is high. Field events are taken at the trailing (falling) edge of the vertical pulse. Line events are taken at the trailing edge of the horizontal pulse. The output therefore never moves while the horizontal pulse is high, which gives the panel a setup and hold margin around the sync edge. A new pattern code is latched only at a field event, so a field never shows a mix of two patterns.

Top module: `lcd_pol_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pol_out` is 0.
- R2: With code `pat_sel`=2'b00 (frame) and `rate_half`=0, `pol_out` equals the base polarity. The base polarity inverts one cycle after each falling edge of `vsync_in`.
- R3: With `rate_half`=1, the base polarity inverts only on every second falling edge of `vsync_in`. After reset, the first such edge leaves it at 0 and the second sets it to 1.
- R4: With code 2'b10 (column), `pol_out` is the base XOR a pixel parity. The pixel parity inverts on each `pix_stb` and clears to 0 at each falling edge of `hsync_in`.
- R5: With code 2'b11 (row), `pol_out` is the base XOR a line parity. The line parity inverts at each falling edge of `hsync_in` and clears to 0 at each falling edge of `vsync_in`.
- R6: With code 2'b01 (checkerboard), `pol_out` is the base XOR the line parity XOR the pixel parity.
- R7: A change of `pat_sel` has no effect on `pol_out` until the next falling edge of `vsync_in`, which latches the new code.
- R8: While `hsync_in` is high, `pol_out` does not change unless a falling edge of `vsync_in` occurs. `pix_stb` pulses seen while `hsync_in` is high are ignored.
- R9: When `vsync_in` and `hsync_in` fall in the same cycle, the field event wins. The base updates as in R2/R3, and both the line and pixel parities clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 2 | Pattern code: 00 frame, 01 checkerboard, 10 column, 11 row |
| rate_half | input | 1 | 1: base polarity flips every second field |
| vsync_in | input | 1 | Vertical sync pulse, active high |
| hsync_in | input | 1 | Horizontal sync pulse, active high |
| pix_stb | input | 1 | One-cycle strobe per pixel |
| pol_out | output | 1 | Polarity inversion control |

## Verification
A field event and a line event can land in the same cycle when both sync pulses end together. They can also overlap when a pixel strobe arrives while the horizontal pulse is still high. The bench drives both sync inputs high, lowers them on the same edge in row mode, and expects the line parity to restart at 0 rather than invert. It also issues strobes during the horizontal pulse and expects the output to hold. A behavioural model is compared with the output on every clock across directed and pseudo-random fields.

// File: rtl/lcdpol_pkg.sv
package lcdpol_pkg;
  typedef enum logic [1:0] {
    PAT_FRAME  = 2'b00,
    PAT_CHECK  = 2'b01,
    PAT_COLUMN = 2'b10,
    PAT_ROW    = 2'b11
  } pat_e;

  // Combine field base with line/pixel parities for the active pattern
  function automatic logic pol_mix(input pat_e p, input logic base,
                                   input logic row, input logic pix);
    logic term;
    case (p)
      PAT_CHECK:  term = row ^ pix;
      PAT_COLUMN: term = pix;
      PAT_ROW:    term = row;
      default:    term = 1'b0;
    endcase
    return base ^ term;
  endfunction
endpackage

// File: rtl/lcdpol_fall.sv
module lcdpol_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/lcdpol_field.sv
module lcdpol_field
  import lcdpol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fld_evt,
  input  logic       rate_half,
  input  logic [1:0] pat_sel,
  output logic       base,
  output pat_e       mode_act
);
  logic pair_q;
  logic flip_now;

  assign flip_now = fld_evt & (~rate_half | pair_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q   <= 1'b0;
      base     <= 1'b0;
      mode_act <= PAT_FRAME;
    end else if (fld_evt) begin
      pair_q   <= ~pair_q;
      mode_act <= pat_e'(pat_sel);
      if (flip_now) base <= ~base;
    end
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_evt |=> $stable(base) && $stable(mode_act)); // R7
  AST_FULL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    fld_evt && !rate_half |=> base != $past(base)); // R2
  AST_HALF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    fld_evt && rate_half && !pair_q |=> $stable(base)); // R3
endmodule

// File: rtl/lcdpol_line.sv
module lcdpol_line (
  input  logic clk,
  input  logic rst_n,
  input  logic fld_evt,
  input  logic ln_evt,
  input  logic pix_stb,
  input  logic hs_lvl,
  output logic row_par,
  output logic pix_par
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_par <= 1'b0;
      pix_par <= 1'b0;
    end else if (fld_evt) begin
      row_par <= 1'b0;
      pix_par <= 1'b0;
    end else if (ln_evt) begin
      row_par <= ~row_par;
      pix_par <= 1'b0;
    end else if (pix_stb && !hs_lvl) begin
      pix_par <= ~pix_par;
    end
  end

  AST_FIELD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fld_evt |=> !row_par && !pix_par); // R9
  AST_LINE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ln_evt && !fld_evt |=> row_par != $past(row_par)); // R5
  AST_LINE_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    ln_evt |=> !pix_par); // R4
  AST_SYNC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lvl && !fld_evt |=> $stable(pix_par) && $stable(row_par)); // R8
endmodule

// File: rtl/lcd_pol_ctl.sv
module lcd_pol_ctl
  import lcdpol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pat_sel,
  input  logic       rate_half,
  input  logic       vsync_in,
  input  logic       hsync_in,
  input  logic       pix_stb,
  output logic       pol_out
);
  logic fld_evt;
  logic ln_evt;
  logic base;
  pat_e mode_act;
  logic row_par;
  logic pix_par;

  lcdpol_fall u_vfall (.clk(clk), .rst_n(rst_n), .lvl(vsync_in), .fall(fld_evt));
  lcdpol_fall u_hfall (.clk(clk), .rst_n(rst_n), .lvl(hsync_in), .fall(ln_evt));

  lcdpol_field u_field (
    .clk(clk), .rst_n(rst_n), .fld_evt(fld_evt), .rate_half(rate_half),
    .pat_sel(pat_sel), .base(base), .mode_act(mode_act)
  );

  lcdpol_line u_line (
    .clk(clk), .rst_n(rst_n), .fld_evt(fld_evt), .ln_evt(ln_evt),
    .pix_stb(pix_stb), .hs_lvl(hsync_in), .row_par(row_par), .pix_par(pix_par)
  );

  assign pol_out = pol_mix(mode_act, base, row_par, pix_par);

  AST_HS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hsync_in) && !$past(fld_evt) |-> $stable(pol_out)); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    !$past(rst_n) |-> !pol_out); // R1
endmodule

// File: tb/test_lcd_pol_ctl.sv
module test_lcd_pol_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pat_sel = 2'b00;
  logic rate_half = 1'b0;
  logic vsync_in = 1'b0;
  logic hsync_in = 1'b0;
  logic pix_stb = 1'b0;
  logic pol_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  lcd_pol_ctl i_lcd_pol_ctl (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .rate_half(rate_half),
    .vsync_in(vsync_in), .hsync_in(hsync_in), .pix_stb(pix_stb), .pol_out(pol_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit m_vs, m_hs, m_base, m_pair, m_row, m_pix;
  bit [1:0] m_mode;
  int fields_seen;

  function automatic bit model_pol();
    bit r;
    r = m_base;
    if (m_mode == 2'b11) r = r ^ m_row;
    if (m_mode == 2'b10) r = r ^ m_pix;
    if (m_mode == 2'b01) r = r ^ m_row ^ m_pix;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vs = 0; m_hs = 0; m_base = 0; m_pair = 0; m_row = 0; m_pix = 0;
      m_mode = 0; fields_seen = 0;
    end else begin
      if (m_vs && !vsync_in) begin
        fields_seen++;
        if (rate_half == 0) m_base = !m_base;
        else if (fields_seen % 2 == 0) m_base = !m_base;
        m_mode = pat_sel;
        m_row = 0; m_pix = 0;
      end else if (m_hs && !hsync_in) begin
        m_row = !m_row; m_pix = 0;
      end else if (pix_stb && !hsync_in) begin
        m_pix = !m_pix;
      end
      m_vs = vsync_in; m_hs = hsync_in;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pol_out !== (rst_n ? model_pol() : 1'b0)) begin
        errors++;
        $display("FAIL %s per-cycle: pol_out=%b expected=%b at %0t",
                 cur_req, pol_out, rst_n ? model_pol() : 1'b0, $time);
      end
    end
  end

  task automatic chk(input string req, input logic exp);
    checks++;
    if (pol_out !== exp) begin
      errors++;
      $display("FAIL %s: pol_out=%b expected=%b at %0t", req, pol_out, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; vsync_in = 0; hsync_in = 0; pix_stb = 0;
    repeat (3) @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 1'b0);
  endtask

  task automatic vs_pulse();
    vsync_in = 1; repeat (2) @(negedge clk);
    vsync_in = 0; @(negedge clk);
  endtask

  task automatic hs_pulse();
    hsync_in = 1; repeat (2) @(negedge clk);
    hsync_in = 0; @(negedge clk);
  endtask

  task automatic strobe();
    pix_stb = 1; @(negedge clk);
    pix_stb = 0; @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: expired actual=hung expected=finish");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    do_reset();

    // R2 frame inversion, full rate
    cur_req = "R2"; pat_sel = 2'b00; rate_half = 0;
    vs_pulse(); chk("R2", 1'b1);
    hs_pulse(); strobe(); chk("R2", 1'b1);
    vs_pulse(); chk("R2", 1'b0);

    // R3 half rate
    cur_req = "R3"; rate_half = 1; do_reset();
    vs_pulse(); chk("R3", 1'b0);
    vs_pulse(); chk("R3", 1'b1);
    vs_pulse(); chk("R3", 1'b1);
    vs_pulse(); chk("R3", 1'b0);

    // R4 column: base 1 after one field
    cur_req = "R4"; rate_half = 0; do_reset();
    pat_sel = 2'b10; vs_pulse(); chk("R4", 1'b1);
    strobe(); chk("R4", 1'b0);
    strobe(); chk("R4", 1'b1);
    strobe(); chk("R4", 1'b0);
    hs_pulse(); chk("R4", 1'b1);

    // R5 row: base goes to 0
    cur_req = "R5"; pat_sel = 2'b11; vs_pulse(); chk("R5", 1'b0);
    hs_pulse(); chk("R5", 1'b1);
    strobe(); chk("R5", 1'b1);
    hs_pulse(); chk("R5", 1'b0);

    // R6 checkerboard: base 1
    cur_req = "R6"; pat_sel = 2'b01; vs_pulse(); chk("R6", 1'b1);
    hs_pulse(); chk("R6", 1'b0);
    strobe(); chk("R6", 1'b1);

    // R7 code change mid-field stays pending (row 1, pix 1 now)
    cur_req = "R7"; pat_sel = 2'b00;
    hs_pulse(); chk("R7", 1'b1);
    strobe(); chk("R7", 1'b0);
    vs_pulse(); chk("R7", 1'b0);
    strobe(); chk("R7", 1'b0);

    // R8 hold during HS high, strobes ignored (column, base 1)
    cur_req = "R8"; pat_sel = 2'b10; vs_pulse(); chk("R8", 1'b1);
    hsync_in = 1;
    for (int k = 0; k < 4; k++) begin
      pix_stb = 1; @(negedge clk); chk("R8", 1'b1);
    end
    pix_stb = 0; hsync_in = 0; @(negedge clk); chk("R8", 1'b1);
    strobe(); chk("R8", 1'b0);
    hs_pulse(); chk("R8", 1'b1);

    // R9 coincident field and line end; row parity is 0 before
    cur_req = "R9"; pat_sel = 2'b11;
    vsync_in = 1; hsync_in = 1; repeat (2) @(negedge clk);
    vsync_in = 0; hsync_in = 0; @(negedge clk);
    chk("R9", 1'b0);
    hs_pulse(); chk("R9", 1'b1);

    // Pseudo-random fields compared per cycle
    cur_req = "R6";
    begin
      logic [7:0] lf = 8'h5a;
      for (int f = 0; f < 12; f++) begin
        pat_sel = lf[1:0]; rate_half = lf[2];
        vs_pulse();
        for (int l = 0; l < 5; l++) begin
          hs_pulse();
          for (int p = 0; p < 7; p++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            pix_stb = lf[0]; @(negedge clk);
          end
          pix_stb = 0;
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule